// File: doc/BRIEF.md
# Duty-Cycled Wake Controller

This block puts a magnetic-sensor front end to sleep for almost all of each measurement frame and wakes it briefly once per frame. A one-cycle pulse on `slow_tick` comes from the low-rate frame oscillator, nominally at 20 Hz. Each pulse that arrives while the front end sleeps opens a wake window of fixed length. For that window the controller raises the fast-oscillator enable, the sensor bias and the analog enable. It also lets the measurement sequencer run after a short settling lead. When the window closes, every enable drops together, and only the slow oscillator and the output driver stay powered.

The block is clocked by a timebase that runs at twice the fast oscillator's rate, so one `clk` cycle is one half-period of the fast clock. The default window is 19 half-periods, which gives the exact 9.5-cycle awake time. It is about 57 µs of each 50 ms frame. The sequencer reports completion on `meas_done`. The digital output register holds its value while `out_hold` is high. It is opened for one cycle at the very end of a window, and only when that window's measurement completed.

All pins are plain control levels or strobes. There is no data stream, so no valid/ready handshake applies.

Top module: `duty_wake_ctrl`

## Requirements
- R1: Out of reset and throughout sleep, `fast_clk_en`, `bias_en`, `analog_en` and `seq_run` are low and `out_hold` is high.
- R2: A `slow_tick` sampled high while asleep makes `fast_clk_en` go high in the next cycle and stay high for exactly WAKE_HALVES cycles (default 19), after which the block is asleep again.
- R3: A `slow_tick` sampled while a window is open, including during its last cycle, has no effect: the window still ends after WAKE_HALVES cycles and no second window follows.
- R4: `bias_en` and `analog_en` are high in exactly the same cycles as `fast_clk_en`.
- R5: `seq_run` first rises in window cycle BIAS_LEAD (default 2, one fast-clock period), counting the first window cycle as 0, so bias has settled before the sequencer runs.
- R6: `meas_done` sampled high in window cycle k makes `seq_run` low from cycle k+1 to the end of that window.
- R7: `out_hold` is low for exactly one cycle, the last cycle of a window, if and only if `meas_done` was sampled high in an earlier cycle of that window. At all other times it is high.
- R8: `meas_done` while asleep is ignored, and the completion record is cleared when each window opens. A later window without `meas_done` therefore never opens the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase; one cycle per fast-clock half-period |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle frame pulse from the slow oscillator, synchronous to clk |
| meas_done | input | 1 | Sequencer reports the measurement is complete |
| fast_clk_en | output | 1 | Enable for the fast oscillator |
| bias_en | output | 1 | Enable for the sensing-element bias |
| analog_en | output | 1 | Power enable for the amplifier and comparator chain |
| seq_run | output | 1 | Lets the measurement sequencers advance |
| out_hold | output | 1 | High keeps the output register frozen; low for one cycle loads it |

## Verification
Every result is due one register stage after its cause. A tick sampled at an edge shows as enables in the cycle that follows. The settling lead then adds two more cycles before `seq_run`. A completion sampled in window cycle k drops `seq_run` in cycle k+1, and the output strobe appears in the window's final cycle. The bench drives inputs and samples outputs on the falling edge. It tracks the window cycle index itself, so each expectation is compared in the exact cycle the requirement names. It sweeps the completion over every window position and the stray tick over every window position.

// File: rtl/wake_pkg.sv
package wake_pkg;

  // Power and sequencing controls presented by the controller.
  typedef struct packed {
    logic fast_clk_en;
    logic bias_en;
    logic analog_en;
    logic seq_run;
    logic out_hold;
  } pwr_ctl_t;

endpackage

// File: rtl/wake_timer.sv
// Wake-window timer: opens on a tick while asleep, closes after HALVES cycles.
module wake_timer #(
  parameter int HALVES = 19,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic          awake,
  output logic [CW-1:0] cnt,
  output logic          start,
  output logic          last
);

  localparam logic [CW-1:0] LastIdx = CW'(HALVES - 1);

  assign start = tick && !awake;
  assign last  = awake && (cnt == LastIdx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      awake <= 1'b1;
      cnt   <= '0;
    end else if (awake) begin
      if (last) begin
        awake <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/done_tracker.sv
// Remembers that the sequencer finished inside the current window.
module done_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic awake,
  input  logic meas_done,
  output logic done_seen
);

  always_ff @(posedge clk) begin
    if (!rst_n)                done_seen <= 1'b0;
    else if (start)            done_seen <= 1'b0;
    else if (awake && meas_done) done_seen <= 1'b1;
  end

endmodule

// File: rtl/power_decode.sv
// Maps window state onto the power and sequencing controls.
module power_decode #(
  parameter int LEAD = 2,
  parameter int CW   = 5
) (
  input  logic              awake,
  input  logic [CW-1:0]     cnt,
  input  logic              last,
  input  logic              done_seen,
  output wake_pkg::pwr_ctl_t ctl
);

  localparam logic [CW-1:0] LeadIdx = CW'(LEAD);

  always_comb begin
    ctl.fast_clk_en = awake;
    ctl.bias_en     = awake;
    ctl.analog_en   = awake;
    ctl.seq_run     = awake && (cnt >= LeadIdx) && !done_seen;
    ctl.out_hold    = !(last && done_seen);
  end

endmodule

// File: rtl/duty_wake_ctrl.sv
module duty_wake_ctrl #(
  parameter int WAKE_HALVES = 19,
  parameter int BIAS_LEAD   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic meas_done,
  output logic fast_clk_en,
  output logic bias_en,
  output logic analog_en,
  output logic seq_run,
  output logic out_hold
);

  localparam int CW = $clog2(WAKE_HALVES + 1);

  logic          awake, start, last, done_seen;
  logic [CW-1:0] cnt;
  wake_pkg::pwr_ctl_t ctl;

  wake_timer #(.HALVES(WAKE_HALVES), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick),
    .awake(awake), .cnt(cnt), .start(start), .last(last)
  );

  done_tracker u_done (
    .clk(clk), .rst_n(rst_n), .start(start), .awake(awake),
    .meas_done(meas_done), .done_seen(done_seen)
  );

  power_decode #(.LEAD(BIAS_LEAD), .CW(CW)) u_dec (
    .awake(awake), .cnt(cnt), .last(last), .done_seen(done_seen), .ctl(ctl)
  );

  assign fast_clk_en = ctl.fast_clk_en;
  assign bias_en     = ctl.bias_en;
  assign analog_en   = ctl.analog_en;
  assign seq_run     = ctl.seq_run;
  assign out_hold    = ctl.out_hold;

endmodule

// File: rtl/duty_wake_ctrl_chk.sv
module duty_wake_ctrl_chk #(
  parameter int WAKE_HALVES = 19,
  parameter int BIAS_LEAD   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fast_clk_en,
  input logic bias_en,
  input logic analog_en,
  input logic seq_run,
  input logic out_hold
);

  // Length of the current run of enabled cycles, counted in the checker.
  logic [15:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)           run_len <= '0;
    else if (fast_clk_en) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_clk_en |-> (!seq_run && out_hold));

  a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_clk_en) |-> (run_len == 16'(WAKE_HALVES)));

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_en |-> (run_len < 16'(WAKE_HALVES)));

  a_r4_enables_together: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en == fast_clk_en) && (analog_en == fast_clk_en));

  a_r5_bias_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_run) |-> (run_len == 16'(BIAS_LEAD)));

  a_r7_update_last: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hold |=> !fast_clk_en);

endmodule

bind duty_wake_ctrl duty_wake_ctrl_chk #(
  .WAKE_HALVES(WAKE_HALVES), .BIAS_LEAD(BIAS_LEAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_clk_en(fast_clk_en), .bias_en(bias_en),
  .analog_en(analog_en), .seq_run(seq_run), .out_hold(out_hold)
);

// File: tb/duty_wake_ctrl_test.sv
`timescale 1ns/1ps
module duty_wake_ctrl_test;

  localparam int N    = 19;
  localparam int LEAD = 2;

  logic clk = 1'b0;
  logic rst_n, slow_tick, meas_done;
  logic fast_clk_en, bias_en, analog_en, seq_run, out_hold;
  int   total = 0;
  int   fails = 0;
  bit   done_flag = 0;

  always #4 clk = ~clk;

  duty_wake_ctrl #(.WAKE_HALVES(N), .BIAS_LEAD(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .meas_done(meas_done),
    .fast_clk_en(fast_clk_en), .bias_en(bias_en), .analog_en(analog_en),
    .seq_run(seq_run), .out_hold(out_hold)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Sample while asleep: all enables low, hold high.
  task automatic chk_sleep(input string req);
    check(req, "fast_clk_en", int'(fast_clk_en), 0);
    check(req, "bias_en",     int'(bias_en),     0);
    check(req, "analog_en",   int'(analog_en),   0);
    check(req, "seq_run",     int'(seq_run),     0);
    check(req, "out_hold",    int'(out_hold),    1);
  endtask

  // One window; done_at / tick_at give the window cycle of a stimulus, -1 for none.
  task automatic run_window(input int done_at, input int tick_at);
    bit early_done;
    string hold_tag;
    hold_tag = (done_at < 0) ? "R8" : "R7";
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    for (int i = 0; i < N; i++) begin
      early_done = (done_at >= 0) && (done_at < i);
      check("R2", "fast_clk_en", int'(fast_clk_en), 1);
      check("R4", "bias_en",     int'(bias_en),     1);
      check("R4", "analog_en",   int'(analog_en),   1);
      check((i < LEAD) ? "R5" : "R6", "seq_run", int'(seq_run),
            int'((i >= LEAD) && !early_done));
      check(hold_tag, "out_hold", int'(out_hold),
            int'(!((i == N-1) && (done_at >= 0) && (done_at < N-1))));
      meas_done = (i == done_at);
      slow_tick = (i == tick_at);
      @(negedge clk);
    end
    meas_done = 1'b0;
    slow_tick = 1'b0;
    chk_sleep((tick_at >= 0) ? "R3" : "R2");
    @(negedge clk);
    chk_sleep("R1");
  endtask

  initial begin
    rst_n = 1'b0; slow_tick = 1'b0; meas_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_sleep("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_sleep("R1");

    // Completion swept over every window cycle, plus none (R6, R7).
    for (int d = -1; d < N; d++) run_window(d, -1);
    // Record cleared by a new window (R8).
    run_window(-1, -1);
    // Stray tick at every window cycle (R3).
    for (int t = 0; t < N; t++) run_window(-1, t);

    // Completion while asleep is ignored (R8).
    @(negedge clk); meas_done = 1'b1;
    @(negedge clk); meas_done = 1'b0;
    chk_sleep("R8");
    run_window(-1, -1);

    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      total++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule